// File: doc/BRIEF.md
# Display Panel Power Sequencer

This block brings a flat-panel display up and down in the order that panels demand. Software writes a control word to ask for power. Once the upstream display path reports ready, the block walks through three timed power-up substates. In these it raises the panel supply, then the panel enable, and only at the end permits the backlight. Removing the request walks the same rails down in reverse, through three power-down substates. A status word always exposes the current substate code, the direction of any sequence in progress and whether the mandatory off-to-on recovery delay is still running.

All waits are counted in ticks of a programmable prescaler that divides the core clock. The delay and divisor words can only be changed while a 16-bit key sits in the upper half of the control word. A power-reset bit parks the machine in a dedicated state with every output low. A force bit holds the supply rail up outside that state.

Top module: `panel_power_sequencer`

## Requirements
- R1: After `rst_n` is released, the status word reads 0 apart from bit 30, which equals `ready_i`. The control, on-delay, off-delay and divisor words read 0, and all three panel outputs are low.
- R2: The status word reports the panel-on flag in bit 31 (set only in on-idle), `ready_i` in bit 30, the direction in bits 29:28 (0 idle, 1 powering up, 2 powering down), the recovery flag in bit 27 and the substate code in bits 3:0. The codes are off-idle 0x0, down steps 0x1/0x2/0x3, on-idle 0x8, up steps 0x9/0xA/0xB and power-reset 0xF. All other bits read 0.
- R3: Control bit 0 requests power. From off-idle the machine moves to 0x9 only while both that bit and `ready_i` are high. While `ready_i` is low it stays in 0x0.
- R4: Power-up runs 0x9 → 0xA → 0xB → 0x8. In 0xA only the supply is high, for the up delay. In 0xB the supply and enable are high, for the light-on delay. The backlight follows control bit 2 only in 0x8.
- R5: Power-down runs 0x8 → 0x1 → 0x2 → 0x3 → 0x0. 0x1 has the backlight low and supply and enable high, for the light-off delay. 0x2 has only the supply high, for the down delay. 0x3 lasts one clock with all outputs low.
- R6: Entering 0x0 from 0x3 starts the recovery counter with the 5-bit cycle delay. Status bit 27 is high while the counter is nonzero. A later power-up waits in 0x9 until the counter has expired.
- R7: Clearing control bit 0 during power-up branches at once: 0x9 goes to 0x0, 0xA goes to 0x3 and 0xB goes to 0x2. The down sequence then continues normally.
- R8: While control bit 1 is set, the machine sits in 0xF with all outputs low. After release it moves to 0x0.
- R9: Control bit 3 drives the supply output high in every state except 0xF, without raising the enable.
- R10: Writes to the on-delay, off-delay and divisor words take effect only while control bits 31:16 hold 0xABCD. Otherwise they leave the stored value unchanged.
- R11: A wait of N ticks keeps a substate for N+1 clocks when the divider is 1. With divider D it keeps the substate for between (N-1)·D+2 and N·D+1 clocks. A divider of 0 behaves as 1.
- R12: The byte offsets are 0x00 status (read-only), 0x04 control, 0x08 on-delays, 0x0C off-delays and 0x10 divisor. Read data appears on the clock after the read strobe, and unmapped offsets read 0.
- R13: The on-delay word holds the up delay in bits 28:16, the light-on delay in bits 12:0 and a 2-bit port select in bits 31:30. The off-delay word holds the down delay in 28:16 and the light-off delay in 12:0. The divisor word holds the 24-bit divider in bits 31:8 and the cycle delay in bits 4:0. The control word reads back its key in 31:16 and bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ready_i | input | 1 | Upstream clock, pipe and port all active |
| wr_en | input | 1 | Single-cycle register write strobe |
| rd_en | input | 1 | Single-cycle register read strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the clock after `rd_en` |
| vdd_o | output | 1 | Panel supply enable |
| panel_en_o | output | 1 | Panel enable |
| backlight_o | output | 1 | Backlight enable |

## Verification
A wrong substate shows in the status code on the read that follows it. The panel outputs reveal it on the same clock, because they decode directly from the state register. A counter loaded with the wrong value, or a prescaler with the wrong period, shows as a substate that lasts the wrong number of clocks. The bench therefore reads status on every clock during a sequence and compares each substate's length with the delay arithmetic. A broken key gate or a leaking recovery flag shows up on the next readback of the affected word.

// File: rtl/pnlseq_pkg.sv
package pnlseq_pkg;

   localparam int ST_W       = 4;
   localparam int REG_W      = 32;
   localparam logic [15:0] UNLOCK_KEY = 16'hABCD;

   // sequence substate codes (software decodes these)
   typedef enum logic [ST_W-1:0] {
      ST_OFF = 4'h0,
      ST_PD1 = 4'h1,
      ST_PD2 = 4'h2,
      ST_PD3 = 4'h3,
      ST_ON  = 4'h8,
      ST_PU1 = 4'h9,
      ST_PU2 = 4'hA,
      ST_PU3 = 4'hB,
      ST_RST = 4'hF
   } seq_state_t;

   // direction field values
   localparam logic [1:0] DIR_IDLE = 2'd0;
   localparam logic [1:0] DIR_UP   = 2'd1;
   localparam logic [1:0] DIR_DOWN = 2'd2;

   // byte offsets
   localparam int OFS_STAT = 'h00;
   localparam int OFS_CTRL = 'h04;
   localparam int OFS_ONDL = 'h08;
   localparam int OFS_OFDL = 'h0C;
   localparam int OFS_DIVR = 'h10;

   // field positions
   localparam int POS_HI   = 16;   // upper delay / key
   localparam int POS_PORT = 30;
   localparam int POS_DIV  = 8;
   localparam int MAX_DLY  = 13;
   localparam int MAX_DIV  = 24;
   localparam int MAX_CYC  = 5;

endpackage

// File: rtl/pnl_tick_gen.sv
module pnl_tick_gen #(
   parameter int DIV_W    = 24,
   parameter bit PRESCALE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   generate
      if (PRESCALE) begin : g_div
         logic [DIV_W-1:0] cnt_q;
         logic [DIV_W-1:0] last;

         // a divider of zero is treated as one
         assign last = (div == '0) ? '0 : div - DIV_W'(1);
         assign tick = (cnt_q >= last);

         always_ff @(posedge clk) begin
            if (!rst_n)    cnt_q <= '0;
            else if (tick) cnt_q <= '0;
            else           cnt_q <= cnt_q + DIV_W'(1);
         end
      end else begin : g_bypass
         logic unused_div;
         assign unused_div = ^div;
         assign tick = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/pnl_delay_cnt.sv
module pnl_delay_cnt #(
   parameter int W = 13
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         tick,
   output logic         zero
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (load)                   cnt_q <= load_val;
      else if (tick && cnt_q != '0)    cnt_q <= cnt_q - W'(1);
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/pnl_seq_regs.sv
module pnl_seq_regs
   import pnlseq_pkg::*;
#(
   parameter int DLY_W  = 13,
   parameter int DIV_W  = 24,
   parameter int CYC_W  = 5,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   input  logic [REG_W-1:0]  status,
   output logic [REG_W-1:0]  rdata,
   output logic              on_req,
   output logic              pwr_rst,
   output logic              bl_en,
   output logic              force_vdd,
   output logic [DLY_W-1:0]  up_dly,
   output logic [DLY_W-1:0]  lon_dly,
   output logic [DLY_W-1:0]  dn_dly,
   output logic [DLY_W-1:0]  loff_dly,
   output logic [DIV_W-1:0]  div,
   output logic [CYC_W-1:0]  cyc_dly
);

   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_ONDL = ADDR_W'(OFS_ONDL);
   localparam logic [ADDR_W-1:0] A_OFDL = ADDR_W'(OFS_OFDL);
   localparam logic [ADDR_W-1:0] A_DIVR = ADDR_W'(OFS_DIVR);

   logic [15:0]      key_q;
   logic [3:0]       ctl_q;
   logic [1:0]       port_q;
   logic [DLY_W-1:0] up_q, lon_q, dn_q, loff_q;
   logic [DIV_W-1:0] div_q;
   logic [CYC_W-1:0] cyc_q;
   logic             unlocked;
   logic [REG_W-1:0] rd_word;
   logic [REG_W-1:0] rdata_q;
   logic             unused_wbits;

   assign unlocked     = (key_q == UNLOCK_KEY);
   assign unused_wbits = ^wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         key_q  <= '0;
         ctl_q  <= '0;
         port_q <= '0;
         up_q   <= '0;
         lon_q  <= '0;
         dn_q   <= '0;
         loff_q <= '0;
         div_q  <= '0;
         cyc_q  <= '0;
      end else if (wr_en) begin
         if (addr == A_CTRL) begin
            key_q <= wdata[POS_HI +: 16];
            ctl_q <= wdata[3:0];
         end
         if (addr == A_ONDL && unlocked) begin
            port_q <= wdata[POS_PORT +: 2];
            up_q   <= wdata[POS_HI +: DLY_W];
            lon_q  <= wdata[0 +: DLY_W];
         end
         if (addr == A_OFDL && unlocked) begin
            dn_q   <= wdata[POS_HI +: DLY_W];
            loff_q <= wdata[0 +: DLY_W];
         end
         if (addr == A_DIVR && unlocked) begin
            div_q <= wdata[POS_DIV +: DIV_W];
            cyc_q <= wdata[0 +: CYC_W];
         end
      end
   end

   always_comb begin
      rd_word = '0;
      if (addr == A_STAT) begin
         rd_word = status;
      end else if (addr == A_CTRL) begin
         rd_word[POS_HI +: 16] = key_q;
         rd_word[3:0]          = ctl_q;
      end else if (addr == A_ONDL) begin
         rd_word[POS_PORT +: 2]   = port_q;
         rd_word[POS_HI +: DLY_W] = up_q;
         rd_word[0 +: DLY_W]      = lon_q;
      end else if (addr == A_OFDL) begin
         rd_word[POS_HI +: DLY_W] = dn_q;
         rd_word[0 +: DLY_W]      = loff_q;
      end else if (addr == A_DIVR) begin
         rd_word[POS_DIV +: DIV_W] = div_q;
         rd_word[0 +: CYC_W]       = cyc_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata_q <= '0;
      else if (rd_en) rdata_q <= rd_word;
   end

   assign rdata     = rdata_q;
   assign on_req    = ctl_q[0];
   assign pwr_rst   = ctl_q[1];
   assign bl_en     = ctl_q[2];
   assign force_vdd = ctl_q[3];
   assign up_dly    = up_q;
   assign lon_dly   = lon_q;
   assign dn_dly    = dn_q;
   assign loff_dly  = loff_q;
   assign div       = div_q;
   assign cyc_dly   = cyc_q;

endmodule

// File: rtl/pnl_seq_fsm.sv
module pnl_seq_fsm
   import pnlseq_pkg::*;
#(
   parameter int DLY_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             on_req,
   input  logic             pwr_rst,
   input  logic             bl_en,
   input  logic             force_vdd,
   input  logic             ready,
   input  logic             dly_zero,
   input  logic             cyc_zero,
   input  logic [DLY_W-1:0] up_dly,
   input  logic [DLY_W-1:0] lon_dly,
   input  logic [DLY_W-1:0] dn_dly,
   input  logic [DLY_W-1:0] loff_dly,
   output seq_state_t       state,
   output logic             dly_load,
   output logic [DLY_W-1:0] dly_val,
   output logic             cyc_load,
   output logic             vdd,
   output logic             pen,
   output logic             bl
);

   seq_state_t st_q, st_d;

   always_comb begin
      st_d     = st_q;
      dly_load = 1'b0;
      dly_val  = '0;
      cyc_load = 1'b0;
      if (pwr_rst) begin
         st_d = ST_RST;
      end else begin
         case (st_q)
            ST_RST: st_d = ST_OFF;
            ST_OFF: if (on_req && ready) st_d = ST_PU1;
            ST_PU1: begin
               if (!on_req) st_d = ST_OFF;
               else if (cyc_zero) begin
                  st_d = ST_PU2; dly_load = 1'b1; dly_val = up_dly;
               end
            end
            ST_PU2: begin
               if (!on_req) st_d = ST_PD3;
               else if (dly_zero) begin
                  st_d = ST_PU3; dly_load = 1'b1; dly_val = lon_dly;
               end
            end
            ST_PU3: begin
               if (!on_req) begin
                  st_d = ST_PD2; dly_load = 1'b1; dly_val = dn_dly;
               end else if (dly_zero) st_d = ST_ON;
            end
            ST_ON: begin
               if (!on_req) begin
                  st_d = ST_PD1; dly_load = 1'b1; dly_val = loff_dly;
               end
            end
            ST_PD1: begin
               if (dly_zero) begin
                  st_d = ST_PD2; dly_load = 1'b1; dly_val = dn_dly;
               end
            end
            ST_PD2: if (dly_zero) st_d = ST_PD3;
            ST_PD3: begin
               st_d = ST_OFF; cyc_load = 1'b1;
            end
            default: st_d = ST_RST;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_OFF;
      else        st_q <= st_d;
   end

   logic rail_vdd;
   always_comb begin
      rail_vdd = 1'b0;
      pen      = 1'b0;
      case (st_q)
         ST_PU2, ST_PD2:        rail_vdd = 1'b1;
         ST_PU3, ST_ON, ST_PD1: begin rail_vdd = 1'b1; pen = 1'b1; end
         default: ;
      endcase
   end

   assign vdd   = rail_vdd | (force_vdd && st_q != ST_RST);
   assign bl    = (st_q == ST_ON) && bl_en;
   assign state = st_q;

endmodule

// File: rtl/panel_power_sequencer.sv
module panel_power_sequencer
   import pnlseq_pkg::*;
#(
   parameter int DLY_W    = 13,
   parameter int DIV_W    = 24,
   parameter int CYC_W    = 5,
   parameter int ADDR_W   = 5,
   parameter bit PRESCALE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ready_i,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic              vdd_o,
   output logic              panel_en_o,
   output logic              backlight_o
);

   generate
      if (DLY_W < 1 || DLY_W > MAX_DLY) begin : g_bad_dly
         $error("DLY_W out of range");
      end
      if (DIV_W < 1 || DIV_W > MAX_DIV) begin : g_bad_div
         $error("DIV_W out of range");
      end
      if (CYC_W < 1 || CYC_W > MAX_CYC) begin : g_bad_cyc
         $error("CYC_W out of range");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("ADDR_W too narrow for register map");
      end
   endgenerate

   logic             on_req, pwr_rst, bl_en, force_vdd;
   logic [DLY_W-1:0] up_dly, lon_dly, dn_dly, loff_dly, dly_val;
   logic [DIV_W-1:0] div;
   logic [CYC_W-1:0] cyc_dly;
   logic             tick, dly_load, dly_zero, cyc_load, cyc_zero;
   seq_state_t       st;
   logic [1:0]       dir;
   logic [31:0]      status;

   always_comb begin
      case (st)
         ST_PU1, ST_PU2, ST_PU3: dir = DIR_UP;
         ST_PD1, ST_PD2, ST_PD3: dir = DIR_DOWN;
         default:                dir = DIR_IDLE;
      endcase
      status        = '0;
      status[31]    = (st == ST_ON);
      status[30]    = ready_i;
      status[29:28] = dir;
      status[27]    = !cyc_zero;
      status[3:0]   = st;
   end

   pnl_seq_regs #(
      .DLY_W(DLY_W), .DIV_W(DIV_W), .CYC_W(CYC_W), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .status(status), .rdata(rdata),
      .on_req(on_req), .pwr_rst(pwr_rst), .bl_en(bl_en), .force_vdd(force_vdd),
      .up_dly(up_dly), .lon_dly(lon_dly), .dn_dly(dn_dly), .loff_dly(loff_dly),
      .div(div), .cyc_dly(cyc_dly)
   );

   pnl_tick_gen #(.DIV_W(DIV_W), .PRESCALE(PRESCALE)) u_tick (
      .clk(clk), .rst_n(rst_n), .div(div), .tick(tick)
   );

   pnl_delay_cnt #(.W(DLY_W)) u_phase_cnt (
      .clk(clk), .rst_n(rst_n), .load(dly_load), .load_val(dly_val),
      .tick(tick), .zero(dly_zero)
   );

   pnl_delay_cnt #(.W(CYC_W)) u_cycle_cnt (
      .clk(clk), .rst_n(rst_n), .load(cyc_load), .load_val(cyc_dly),
      .tick(tick), .zero(cyc_zero)
   );

   pnl_seq_fsm #(.DLY_W(DLY_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .on_req(on_req), .pwr_rst(pwr_rst),
      .bl_en(bl_en), .force_vdd(force_vdd), .ready(ready_i),
      .dly_zero(dly_zero), .cyc_zero(cyc_zero),
      .up_dly(up_dly), .lon_dly(lon_dly), .dn_dly(dn_dly), .loff_dly(loff_dly),
      .state(st), .dly_load(dly_load), .dly_val(dly_val), .cyc_load(cyc_load),
      .vdd(vdd_o), .pen(panel_en_o), .bl(backlight_o)
   );

endmodule

// File: rtl/pnl_seq_checker.sv
module pnl_seq_checker
   import pnlseq_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       ready_i,
   input logic       vdd_o,
   input logic       panel_en_o,
   input logic       backlight_o,
   input logic [3:0] st,
   input logic       cyc_zero
);

   // R3: no start while the upstream path is not ready
   a_r3_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_OFF && !ready_i) |=> (st == ST_OFF || st == ST_RST));

   // R4: supply-only step leads to enable step, abort or reset
   a_r4_up_order: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PU2) |=> (st == ST_PU2 || st == ST_PU3 || st == ST_PD3 || st == ST_RST));

   // R4: backlight appears only in on-idle
   a_r4_bl_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
      backlight_o |-> (st == ST_ON));

   // R5: down sequence keeps its order
   a_r5_down_order: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PD1) |=> (st == ST_PD1 || st == ST_PD2 || st == ST_RST));

   // R5: last down step lasts one clock
   a_r5_last_step: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PD3) |=> (st == ST_OFF || st == ST_RST));

   // R5: enable never without supply
   a_r5_en_needs_vdd: assert property (@(posedge clk) disable iff (!rst_n)
      panel_en_o |-> vdd_o);

   // R6: recovery delay holds the first up step
   a_r6_cycle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PU1 && !cyc_zero) |=> (st == ST_PU1 || st == ST_OFF || st == ST_RST));

   // R8: power-reset state keeps every output low
   a_r8_reset_low: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RST) |-> (!vdd_o && !panel_en_o && !backlight_o));

endmodule

bind panel_power_sequencer pnl_seq_checker u_pnl_seq_checker (
   .clk(clk), .rst_n(rst_n), .ready_i(ready_i), .vdd_o(vdd_o),
   .panel_en_o(panel_en_o), .backlight_o(backlight_o),
   .st(st), .cyc_zero(cyc_zero)
);

// File: tb/test_panel_power_sequencer.sv
module test_panel_power_sequencer;

   localparam logic [4:0]  A_STAT = 5'h00, A_CTRL = 5'h04, A_ONDL = 5'h08,
                           A_OFDL = 5'h0C, A_DIVR = 5'h10;
   localparam logic [31:0] KEY = 32'hABCD0000;

   logic        clk = 1'b0, rst_n = 1'b0, ready = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        vdd, pen, bl;
   int          checks = 0, fails = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   panel_power_sequencer i_panel_power_sequencer (
      .clk(clk), .rst_n(rst_n), .ready_i(ready), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata),
      .vdd_o(vdd), .panel_en_o(pen), .backlight_o(bl)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_rng(input string req, input int act, input int lo, input int hi);
      checks++;
      if (act < lo || act > hi) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk); rd_en = 1'b1; addr = a;
      @(negedge clk); rd_en = 1'b0; d = rdata;
   endtask

   task automatic start_mon();
      addr = A_STAT; rd_en = 1'b1;
      @(negedge clk);
   endtask

   task automatic stop_mon();
      rd_en = 1'b0;
   endtask

   task automatic wait_state(input logic [3:0] s);
      int g = 0;
      while (rdata[3:0] !== s && g < 5000) begin g++; @(negedge clk); end
   endtask

   // length of a substate in clocks, status and outputs at first sight
   task automatic measure(input logic [3:0] s, output int dur,
                          output logic [31:0] st0, output logic [2:0] o0);
      wait_state(s);
      st0 = rdata; o0 = {vdd, pen, bl}; dur = 0;
      while (rdata[3:0] === s && dur < 5000) begin dur++; @(negedge clk); end
   endtask

   // follow the state until off-idle, noting which substates appear
   task automatic follow_to_off(output bit s1, output bit s2, output bit s3, output bit sa);
      int g = 0;
      s1 = 0; s2 = 0; s3 = 0; sa = 0;
      while (rdata[3:0] !== 4'h0 && g < 5000) begin
         if (rdata[3:0] == 4'h1) s1 = 1;
         if (rdata[3:0] == 4'h2) s2 = 1;
         if (rdata[3:0] == 4'h3) s3 = 1;
         if (rdata[3:0] == 4'hA) sa = 1;
         g++; @(negedge clk);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] d, st0;
      logic [2:0]  o0;
      int          dur;
      bit          s1, s2, s3, sa;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(A_STAT, d); chk("R1 status", d, 32'h0);
      rd(A_CTRL, d); chk("R1 control", d, 32'h0);
      rd(A_DIVR, d); chk("R1 divisor", d, 32'h0);
      chk("R1 outputs", {29'b0, vdd, pen, bl}, 32'h0);

      // R12 map: unmapped read and status write ignored
      rd(5'h14, d); chk("R12 unmapped", d, 32'h0);
      wr(A_STAT, 32'hFFFF_FFFF);
      rd(A_STAT, d); chk("R12 status ro", d, 32'h0);

      // R10 locked write ignored
      wr(A_ONDL, 32'h1234_5678);
      rd(A_ONDL, d); chk("R10 locked", d, 32'h0);

      // R10/R13 unlocked writes and field readback
      wr(A_CTRL, KEY);
      rd(A_CTRL, d); chk("R13 control key", d, KEY);
      wr(A_ONDL, 32'h4003_0002);
      wr(A_OFDL, 32'h0004_0002);
      wr(A_DIVR, 32'h0000_0114);
      rd(A_ONDL, d); chk("R13 ondelay", d, 32'h4003_0002);
      rd(A_OFDL, d); chk("R13 offdelay", d, 32'h0004_0002);
      rd(A_DIVR, d); chk("R13 divisor", d, 32'h0000_0114);

      // R10 relock, write rejected
      wr(A_CTRL, 32'h0);
      wr(A_DIVR, 32'h0000_0700);
      rd(A_DIVR, d); chk("R10 relocked", d, 32'h0000_0114);
      wr(A_CTRL, KEY);

      // R3 not ready: request ignored
      wr(A_CTRL, KEY | 32'h1);
      repeat (10) @(negedge clk);
      rd(A_STAT, d); chk("R3 hold off", d, 32'h0);

      // R4/R11 power-up with divider 1
      ready = 1'b1;
      start_mon();
      measure(4'h9, dur, st0, o0); chk("R4 up step1 len", dur, 1);
      measure(4'hA, dur, st0, o0); chk("R11 up step2 len", dur, 4);
      chk("R2 dir up", st0[29:28], 2'd1);
      chk("R4 step2 outputs", o0, 3'b100);
      measure(4'hB, dur, st0, o0); chk("R11 up step3 len", dur, 3);
      chk("R4 step3 outputs", o0, 3'b110);
      wait_state(4'h8);
      stop_mon();
      rd(A_STAT, d); chk("R2 on status", d, 32'hC000_0008);
      chk("R4 no backlight", {29'b0, vdd, pen, bl}, 32'h6);
      wr(A_CTRL, KEY | 32'h5);
      chk("R4 backlight on", {29'b0, vdd, pen, bl}, 32'h7);

      // R5 power-down, R6 recovery delay (cycle delay 20)
      wr(A_CTRL, KEY | 32'h4);
      start_mon();
      measure(4'h1, dur, st0, o0); chk("R5 down step1 len", dur, 3);
      chk("R2 dir down", st0[29:28], 2'd2);
      chk("R5 step1 outputs", o0, 3'b110);
      measure(4'h2, dur, st0, o0); chk("R5 down step2 len", dur, 5);
      chk("R5 step2 outputs", o0, 3'b100);
      measure(4'h3, dur, st0, o0); chk("R5 down step3 len", dur, 1);
      wait_state(4'h0);
      chk("R6 flag set", rdata[27], 1'b1);
      chk("R5 off outputs", {29'b0, vdd, pen, bl}, 32'h0);
      stop_mon();
      wr(A_CTRL, KEY | 32'h1);
      start_mon();
      measure(4'h9, dur, st0, o0); chk_rng("R6 recovery wait", dur, 5, 21);
      wait_state(4'h8);
      stop_mon();
      rd(A_STAT, d); chk("R6 flag clear", d, 32'hC000_0008);

      // R7 abort from supply step
      wr(A_CTRL, KEY);
      start_mon(); wait_state(4'h0); stop_mon();
      repeat (40) @(negedge clk);
      wr(A_ONDL, 32'h0028_0028);
      wr(A_CTRL, KEY | 32'h1);
      start_mon(); wait_state(4'hA); stop_mon();
      wr(A_CTRL, KEY);
      start_mon(); follow_to_off(s1, s2, s3, sa); stop_mon();
      chk("R7 abort 0xA path", {29'b0, s1, s2, s3}, 32'h1);

      // R7 abort from first step while recovery runs
      wr(A_CTRL, KEY | 32'h1);
      start_mon(); wait_state(4'h9); stop_mon();
      wr(A_CTRL, KEY);
      start_mon(); follow_to_off(s1, s2, s3, sa); stop_mon();
      chk("R7 abort 0x9 path", {28'b0, sa, s1, s2, s3}, 32'h0);

      // R7 abort from enable step
      repeat (40) @(negedge clk);
      wr(A_CTRL, KEY | 32'h1);
      start_mon(); wait_state(4'hB); stop_mon();
      wr(A_CTRL, KEY);
      start_mon(); follow_to_off(s1, s2, s3, sa); stop_mon();
      chk("R7 abort 0xB path", {29'b0, s1, s2, s3}, 32'h3);
      repeat (40) @(negedge clk);

      // R9 force supply
      wr(A_CTRL, KEY | 32'h8);
      chk("R9 forced supply", {29'b0, vdd, pen, bl}, 32'h4);

      // R8 power reset
      wr(A_CTRL, KEY | 32'hB);
      rd(A_STAT, d); chk("R8 reset code", d[3:0], 4'hF);
      chk("R8 outputs low", {29'b0, vdd, pen, bl}, 32'h0);
      wr(A_CTRL, KEY);
      rd(A_STAT, d); chk("R8 release", d[3:0], 4'h0);

      // R11 divider 3, recovery 0
      wr(A_DIVR, 32'h0000_0300);
      wr(A_ONDL, 32'h0004_0000);
      wr(A_CTRL, KEY | 32'h1);
      start_mon();
      measure(4'hA, dur, st0, o0); chk_rng("R11 div3 len", dur, 11, 13);
      measure(4'hB, dur, st0, o0); chk("R11 zero delay len", dur, 1);
      wait_state(4'h8); stop_mon();
      wr(A_CTRL, KEY);
      start_mon(); wait_state(4'h0); stop_mon();

      // R11 divider 0 behaves as 1
      wr(A_DIVR, 32'h0);
      rd(A_DIVR, d); chk("R13 divisor zero", d, 32'h0);
      wr(A_CTRL, KEY | 32'h1);
      start_mon();
      measure(4'hA, dur, st0, o0); chk("R11 div0 len", dur, 5);
      wait_state(4'h8); stop_mon();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule